// File: doc/BRIEF.md
# Interrupt Trigger-Mode Port Pair

This block sits on a byte-wide I/O bus and holds two 8-bit registers that tell an interrupt controller, one bit per interrupt line, whether that line is edge- or level-triggered. Each register keeps only the bits that are allowed to change. The other bits are forced to zero on every write. The sixteen bits leave the block as one vector that feeds the interrupt controller directly.

The same decoder also recognises a few other system ports that need a response but have no function here. Accesses to them are accepted and flagged on an error pulse. Stores to them are dropped, and reads from them return all-ones. One port is decoded only for writes. Ports that are not in the decode table get no response. Any access wider than one byte is illegal: it stores nothing and raises the error pulse.

All responses are registered. Read data, the acknowledge and the error pulse appear in the cycle after the strobe and last for one cycle.

Top module: `trig_mode_regs`

## Requirements
- R1: A one-byte write to port 0x04D0 stores the write data ANDed with 0xF8, so bits 2:0 of that register stay 0. The stored value appears on `trig_mode[7:0]` after the write edge. A one-byte read of 0x04D0 returns it on `io_rdata`, with `io_ack` high and `err_pulse` low.
- R2: A one-byte write to port 0x04D1 stores the write data ANDed with 0xDE, so bits 5 and 0 of that register stay 0. The stored value appears on `trig_mode[15:8]`. A one-byte read of 0x04D1 returns it, with `io_ack` high and `err_pulse` low.
- R3: While `rst_n` is low at a clock edge, both registers clear to 0x00 and `io_ack` and `err_pulse` drop.
- R4: Ports 0x00B2, 0x00B3 and 0x0CF9 are stub ports. A write to one of them leaves `trig_mode` unchanged. A read from one of them returns 0xFF with `io_ack` high. Either kind of access pulses `err_pulse`.
- R5: A write to port 0x00F0 leaves `trig_mode` unchanged and pulses `err_pulse`. A read of 0x00F0 is treated as an unmapped port.
- R6: For a port that is not decoded, a read gives `io_ack` low and `io_rdata` 0x00, and a write changes nothing. Neither raises `err_pulse`. All 16 address bits take part in the decode.
- R7: `io_size` gives the access width: 0 means one byte, and 1, 2 and 3 mean wider. Any wider read or write pulses `err_pulse` and changes no register. A wide read of a port decoded for reads returns 0xFF with `io_ack` high.
- R8: `io_ack`, `io_rdata` and `err_pulse` are registered. They are valid only in the cycle after the strobe. In a cycle after one with no strobe, `io_ack` and `err_pulse` are low and `io_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_size | input | 2 | Access width, 0 = one byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid with io_ack |
| io_ack | output | 1 | Port decoded for this read |
| err_pulse | output | 1 | One-cycle flag for a stub access or an illegal width |
| trig_mode | output | 16 | Trigger-mode bits, 0x04D0 register in 7:0 |

## Verification
The hardest case to show from the ports is an access that must have no effect. To do this, the bench first loads both registers with every bit that can be set, using 0xF8 and 0xDE. It then makes each stub write, the write-only write, each unmapped write and each wide write with data 0x00. A store that leaked through would show up as a clear bit on `trig_mode`. The bench also sweeps all 256 data values into both registers, which exercises every mask bit in both polarities. The unmapped addresses include neighbours that differ in one bit and a copy of 0x04D0 with a high address bit set.

// File: rtl/trig_mode_pkg.sv
// Package: shared types for the trigger-mode port block.
// Assumes: a port falls into exactly one decode class.
package trig_mode_pkg;

    // Decode class of the addressed port
    typedef enum logic [2:0] {
        PC_NONE   = 3'd0,
        PC_TRIG0  = 3'd1,
        PC_TRIG1  = 3'd2,
        PC_STUB   = 3'd3,
        PC_WONLY  = 3'd4
    } port_cls_e;

endpackage

// File: rtl/tm_port_decode.sv
// Module: tm_port_decode
// Maps a full I/O address to its decode class. The stub ports come from
// a packed parameter list and are compared in a generate loop.
// Assumes: no address appears in more than one parameter.
module tm_port_decode
    import trig_mode_pkg::*;
#(
    parameter int                        ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]         TRIG0_PORT = 16'h04D0,
    parameter logic [ADDR_W-1:0]         TRIG1_PORT = 16'h04D1,
    parameter logic [ADDR_W-1:0]         WONLY_PORT = 16'h00F0,
    parameter int                        NUM_STUB   = 3,
    parameter logic [NUM_STUB*ADDR_W-1:0] STUB_PORTS = {16'h0CF9, 16'h00B3, 16'h00B2}
) (
    input  logic [ADDR_W-1:0] addr,
    output port_cls_e         cls
);

    logic [NUM_STUB-1:0] stub_hit;

    // One comparator per stub port
    for (genvar g = 0; g < NUM_STUB; g++) begin : g_stub
        assign stub_hit[g] = (addr == STUB_PORTS[g*ADDR_W +: ADDR_W]);
    end

    // Priority-free class select (ports are disjoint)
    always_comb begin
        if (addr == TRIG0_PORT)      cls = PC_TRIG0;
        else if (addr == TRIG1_PORT) cls = PC_TRIG1;
        else if (|stub_hit)          cls = PC_STUB;
        else if (addr == WONLY_PORT) cls = PC_WONLY;
        else                         cls = PC_NONE;
    end

endmodule

// File: rtl/tm_mask_reg.sv
// Module: tm_mask_reg
// One control byte. Bits that are clear in MASK are never stored.
// Assumes: the caller qualifies we with the decode and width checks.
module tm_mask_reg #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] MASK   = 8'hF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    // Store the masked byte; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata & MASK;
    end

endmodule

// File: rtl/tm_resp.sv
// Module: tm_resp
// Registers the read data, the acknowledge and the error pulse for one
// cycle after each strobe.
// Assumes: io_rd and io_wr are never high in the same cycle.
module tm_resp
    import trig_mode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic              wide,
    input  port_cls_e         cls,
    input  logic [DATA_W-1:0] q0,
    input  logic [DATA_W-1:0] q1,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              err
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    logic              rd_hit;
    logic              err_n;
    logic [DATA_W-1:0] rdata_n;

    // A read is acknowledged for the two registers and the stub ports
    assign rd_hit = rd && (cls == PC_TRIG0 || cls == PC_TRIG1 || cls == PC_STUB);

    // Next read data
    always_comb begin
        if (!rd_hit)                     rdata_n = '0;
        else if (wide || cls == PC_STUB) rdata_n = ALL_ONES;
        else if (cls == PC_TRIG0)        rdata_n = q0;
        else                             rdata_n = q1;
    end

    // Next error flag: stub access, write-only write, or an illegal width
    always_comb begin
        err_n = 1'b0;
        if (rd && cls == PC_STUB)                        err_n = 1'b1;
        if (wr && (cls == PC_STUB || cls == PC_WONLY))   err_n = 1'b1;
        if ((rd || wr) && wide)                          err_n = 1'b1;
    end

    // Response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            ack   <= 1'b0;
            err   <= 1'b0;
        end else begin
            rdata <= rdata_n;
            ack   <= rd_hit;
            err   <= err_n;
        end
    end

endmodule

// File: rtl/trig_mode_regs.sv
// Module: trig_mode_regs (top)
// Two masked trigger-mode bytes on a byte-wide I/O bus, plus stub,
// write-only and unmapped port handling.
// Assumes: strobes last one cycle each and are never high together.
module trig_mode_regs
    import trig_mode_pkg::*;
#(
    parameter int                         ADDR_W     = 16,
    parameter int                         DATA_W     = 8,
    parameter int                         SIZE_W     = 2,
    parameter logic [ADDR_W-1:0]          TRIG0_PORT = 16'h04D0,
    parameter logic [ADDR_W-1:0]          TRIG1_PORT = 16'h04D1,
    parameter logic [DATA_W-1:0]          TRIG0_MASK = 8'hF8,
    parameter logic [DATA_W-1:0]          TRIG1_MASK = 8'hDE,
    parameter logic [ADDR_W-1:0]          WONLY_PORT = 16'h00F0,
    parameter int                         NUM_STUB   = 3,
    parameter logic [NUM_STUB*ADDR_W-1:0] STUB_PORTS = {16'h0CF9, 16'h00B3, 16'h00B2}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic                io_rd,
    input  logic                io_wr,
    input  logic [SIZE_W-1:0]   io_size,
    input  logic [DATA_W-1:0]   io_wdata,
    output logic [DATA_W-1:0]   io_rdata,
    output logic                io_ack,
    output logic                err_pulse,
    output logic [2*DATA_W-1:0] trig_mode
);

    port_cls_e         cls;
    logic              wide;
    logic              we0;
    logic              we1;
    logic [DATA_W-1:0] q0;
    logic [DATA_W-1:0] q1;

    // Any size code other than zero is wider than one byte
    assign wide = (io_size != '0);
    assign we0  = io_wr && !wide && (cls == PC_TRIG0);
    assign we1  = io_wr && !wide && (cls == PC_TRIG1);

    tm_port_decode #(
        .ADDR_W    (ADDR_W),
        .TRIG0_PORT(TRIG0_PORT),
        .TRIG1_PORT(TRIG1_PORT),
        .WONLY_PORT(WONLY_PORT),
        .NUM_STUB  (NUM_STUB),
        .STUB_PORTS(STUB_PORTS)
    ) u_dec (
        .addr(io_addr),
        .cls (cls)
    );

    tm_mask_reg #(.DATA_W(DATA_W), .MASK(TRIG0_MASK)) u_reg0 (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we0),
        .wdata(io_wdata),
        .q    (q0)
    );

    tm_mask_reg #(.DATA_W(DATA_W), .MASK(TRIG1_MASK)) u_reg1 (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we1),
        .wdata(io_wdata),
        .q    (q1)
    );

    tm_resp #(.DATA_W(DATA_W)) u_resp (
        .clk  (clk),
        .rst_n(rst_n),
        .rd   (io_rd),
        .wr   (io_wr),
        .wide (wide),
        .cls  (cls),
        .q0   (q0),
        .q1   (q1),
        .rdata(io_rdata),
        .ack  (io_ack),
        .err  (err_pulse)
    );

    assign trig_mode = {q1, q0};

endmodule

// File: rtl/trig_mode_regs_chk.sv
// Module: trig_mode_regs_chk
// Port-level properties for trig_mode_regs, attached by bind.
// Assumes: the default parameters of the top module.
module trig_mode_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic [1:0]  io_size,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic        io_ack,
    input logic        err_pulse,
    input logic [15:0] trig_mode
);

    // R1
    lo_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_size == 2'd0 && io_addr == 16'h04D0)
        |=> trig_mode[7:0] == ($past(io_wdata) & 8'hF8));

    // R1
    lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_mode[2:0] == 3'b000);

    // R2
    hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode[13] == 1'b0) && (trig_mode[8] == 1'b0));

    // R3
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (trig_mode == 16'h0000) && !io_ack && !err_pulse);

    // R7
    wide_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && io_size != 2'd0) |=> err_pulse);

    // R7
    wide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_size != 2'd0) |=> $stable(trig_mode));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd && !io_wr) |=> !io_ack && !err_pulse && io_rdata == 8'h00);

endmodule

bind trig_mode_regs trig_mode_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_size  (io_size),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .io_ack   (io_ack),
    .err_pulse(err_pulse),
    .trig_mode(trig_mode)
);

// File: tb/test_trig_mode_regs.sv
`timescale 1ns/1ps
// Bench: sweeps both masked registers over every data value, then walks
// the stub, write-only, unmapped and wide-access cases.
module test_trig_mode_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [1:0]  io_size = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_ack;
    logic        err_pulse;
    logic [15:0] trig_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trig_mode_regs i_trig_mode_regs (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_size(io_size), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ack(io_ack), .err_pulse(err_pulse),
        .trig_mode(trig_mode)
    );

    // Compare one value and count the result
    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One access; outputs are sampled on the following falling edge
    task automatic acc(input logic [15:0] a, input bit rd, input bit wr,
                       input logic [1:0] sz, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = wr; io_size = sz; io_wdata = d;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0; io_size = '0;
    endtask

    // Read and check data, acknowledge and error
    task automatic rd_chk(input string req, input logic [15:0] a, input logic [1:0] sz,
                          input logic [7:0] exp_d, input bit exp_ack, input bit exp_err);
        acc(a, 1'b1, 1'b0, sz, 8'h00);
        chk(req, {8'h00, io_rdata}, {8'h00, exp_d});
        chk(req, {15'h0, io_ack}, {15'h0, exp_ack});
        chk(req, {15'h0, err_pulse}, {15'h0, exp_err});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] full;
        logic [15:0] unmapped [0:7];
        logic [15:0] stubs [0:2];
        unmapped = '{16'h04D2, 16'h04CF, 16'h0000, 16'hFFFF,
                     16'h00B1, 16'h0CF8, 16'h14D0, 16'h00F1};
        stubs = '{16'h00B2, 16'h00B3, 16'h0CF9};

        repeat (3) @(negedge clk);
        // R3: reset state
        chk("R3 reset", trig_mode, 16'h0000);
        chk("R3 reset ack/err", {14'h0, io_ack, err_pulse}, 16'h0000);
        rst_n = 1'b1;

        // R1 and R2: every data value into both registers
        for (int v = 0; v < 256; v++) begin
            acc(16'h04D0, 1'b0, 1'b1, 2'd0, 8'(v));
            chk("R1 store", {8'h00, trig_mode[7:0]}, {8'h00, 8'(v) & 8'hF8});
            chk("R1 no err", {15'h0, err_pulse}, 16'h0000);
            rd_chk("R1 read", 16'h04D0, 2'd0, 8'(v) & 8'hF8, 1'b1, 1'b0);
            acc(16'h04D1, 1'b0, 1'b1, 2'd0, 8'(~v));
            chk("R2 store", {8'h00, trig_mode[15:8]}, {8'h00, 8'(~v) & 8'hDE});
            chk("R1 kept by R2 write", {8'h00, trig_mode[7:0]}, {8'h00, 8'(v) & 8'hF8});
            rd_chk("R2 read", 16'h04D1, 2'd0, 8'(~v) & 8'hDE, 1'b1, 1'b0);
        end

        // Fill every settable bit so a leaked store is visible
        acc(16'h04D0, 1'b0, 1'b1, 2'd0, 8'hFF);
        acc(16'h04D1, 1'b0, 1'b1, 2'd0, 8'hFF);
        full = 16'hDEF8;
        chk("R1 R2 full", trig_mode, full);

        // R4: stub ports
        foreach (stubs[i]) begin
            acc(stubs[i], 1'b0, 1'b1, 2'd0, 8'h00);
            chk("R4 stub write keep", trig_mode, full);
            chk("R4 stub write err", {15'h0, err_pulse}, 16'h0001);
            rd_chk("R4 stub read", stubs[i], 2'd0, 8'hFF, 1'b1, 1'b1);
        end

        // R5: write-only port
        acc(16'h00F0, 1'b0, 1'b1, 2'd0, 8'h00);
        chk("R5 wonly keep", trig_mode, full);
        chk("R5 wonly err", {15'h0, err_pulse}, 16'h0001);
        rd_chk("R5 wonly read", 16'h00F0, 2'd0, 8'h00, 1'b0, 1'b0);

        // R6: unmapped ports
        foreach (unmapped[i]) begin
            acc(unmapped[i], 1'b0, 1'b1, 2'd0, 8'h00);
            chk("R6 unmapped write keep", trig_mode, full);
            chk("R6 unmapped write err", {15'h0, err_pulse}, 16'h0000);
            rd_chk("R6 unmapped read", unmapped[i], 2'd0, 8'h00, 1'b0, 1'b0);
        end

        // R7: wide accesses of each size
        for (int s = 1; s < 4; s++) begin
            acc(16'h04D0, 1'b0, 1'b1, 2'(s), 8'h00);
            chk("R7 wide write keep", trig_mode, full);
            chk("R7 wide write err", {15'h0, err_pulse}, 16'h0001);
            acc(16'h04D1, 1'b0, 1'b1, 2'(s), 8'h00);
            chk("R7 wide write keep hi", trig_mode, full);
            rd_chk("R7 wide read", 16'h04D0, 2'(s), 8'hFF, 1'b1, 1'b1);
            rd_chk("R7 wide unmapped read", 16'h1234, 2'(s), 8'h00, 1'b0, 1'b1);
        end

        // R8: response lasts one cycle
        acc(16'h04D0, 1'b1, 1'b0, 2'd0, 8'h00);
        @(negedge clk);
        chk("R8 one cycle", {7'h0, io_ack, err_pulse, io_rdata}, 16'h0000);

        // R3: reset in mid-run clears both registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R3 mid reset", trig_mode, 16'h0000);
        rst_n = 1'b1;
        rd_chk("R3 read after reset", 16'h04D1, 2'd0, 8'h00, 1'b1, 1'b0);

        finish_run();
    end

endmodule